// File: doc/BRIEF.md
# Bus Cycle Scheduler with Prefetch

This block sits between a processor's microsequencer, its instruction prefetch queue and a 16-bit external bus. At each scheduling point it decides which request receives the next bus cycle. A single beat engine runs every transaction. Operand accesses of byte, word or long size are broken into 16-bit or 8-bit bus beats. The width of each beat depends on the operand size and on whether the addressed port is flagged as 8 bits wide. Read data returns to the sequencer right-aligned.

Writes are placed in a one-entry pending buffer and acknowledged at once, so the sequencer can carry on executing. A second write waits until the buffered one has left the bus, and so does any operand read. Instruction words are fetched into a three-word pipeline at the address the queue owner supplies. Fetching stops when a change-of-flow hint is raised or when the pipeline has no free slot. A flush input empties the pipeline.

Top module: `bus_cycle_sched`

## Requirements
- R1: When an operand read or a buffered write and a prefetch are both eligible at a scheduling point, the operand access takes the bus first.
- R2: A byte operand uses one bus beat with `bus_byte`=1, and its data is on bits [7:0]. A word operand to a 16-bit port uses one beat with `bus_byte`=0.
- R3: A long operand to a 16-bit port uses two beats. The high 16 bits go first at the operand address and the low 16 bits go at address+2.
- R4: When `narrow_port` is 1 at the start of a transaction, every beat is a byte beat (`bus_byte`=1, data on bits [7:0]). A word becomes two beats and a long becomes four. The most significant byte goes first at the lowest address, and the address steps by 1.
- R5: A prefetch starts only when the pipeline has a free slot, counting a fetch already in flight. No prefetch starts while `cof_hint` or `flush` is 1.
- R6: A write request that finds the pending buffer empty gets `op_ack` in the cycle after it is presented, before any of its beats reach the bus.
- R7: While the pending buffer is full, a further write request gets no `op_ack` until the last beat of the buffered write has been acknowledged.
- R8: A buffered write completes all of its beats on the bus before any later operand read starts.
- R9: `flush` empties the pipeline at once. A prefetch already on the bus completes its handshake, and its word is discarded.
- R10: With no operand request pending and prefetch allowed, prefetches run one after another until the 3-word pipeline is full. `pf_gnt` pulses once per fetch, and words leave `iq_word` in fetch order.
- R11: Each beat holds `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` steady until `bus_ack`. A read returns `op_ack` with right-aligned `op_rdata` in the cycle after its last beat is acknowledged. After reset there is no bus request, no acknowledge and an empty pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req | input | 1 | Sequencer operand request, held until `op_ack` |
| op_we | input | 1 | 1 = write, 0 = read |
| op_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| op_addr | input | AW | Operand address |
| op_wdata | input | 32 | Write data, right-aligned |
| op_ack | output | 1 | One-cycle acknowledge (write accepted, or read done) |
| op_rdata | output | 32 | Read data, right-aligned, valid with `op_ack` |
| pf_addr | input | AW | Address of the next instruction word to fetch |
| cof_hint | input | 1 | Change of flow pending; blocks new prefetches |
| flush | input | 1 | Empties the pipeline and drops an in-flight fetch |
| pf_gnt | output | 1 | Pulses the cycle after a prefetch was started |
| iq_valid | output | 1 | Pipeline holds at least one word |
| iq_word | output | 16 | Oldest instruction word |
| iq_pop | input | 1 | Consume the oldest word |
| narrow_port | input | 1 | Addressed port is 8 bits wide (sampled at start) |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | Beat is a write |
| bus_byte | output | 1 | Beat is a byte beat on bits [7:0] |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | 16 | Beat write data |
| bus_ack | input | 1 | Beat complete |
| bus_rdata | input | 16 | Beat read data |

## Verification
A request presented before a clock edge is scheduled at that edge, and `bus_req` is high for the cycle after it. A beat acknowledged at an edge is complete at that edge. A read's `op_ack` and an instruction word's entry into the pipeline appear one cycle after the last acknowledge, and `pf_gnt` appears one cycle after a fetch starts. A write's `op_ack` appears one cycle after acceptance. The bench drives inputs and samples outputs on the falling edge, so every result it reads was set by a whole rising edge. It waits for handshakes by polling `op_ack` at those points. Ordering and beat shape are judged from a log of bus beats that the bus model records as it acknowledges each one.

// File: rtl/bus_cycle_sched.sv
module bus_cycle_sched #(
  parameter int AW = 24,
  parameter int QDEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_req,
  input  logic          op_we,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] op_addr,
  input  logic [31:0]   op_wdata,
  output logic          op_ack,
  output logic [31:0]   op_rdata,
  input  logic [AW-1:0] pf_addr,
  input  logic          cof_hint,
  input  logic          flush,
  output logic          pf_gnt,
  output logic          iq_valid,
  output logic [15:0]   iq_word,
  input  logic          iq_pop,
  input  logic          narrow_port,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_byte,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata
);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  typedef enum logic [1:0] {K_PF, K_RD, K_WR} kind_e;

  logic          wb_full;
  logic [AW-1:0] wb_addr;
  logic [1:0]    wb_size;
  logic [31:0]   wb_data;

  logic          busy, drop, narrow;
  kind_e         kind;
  logic [AW-1:0] cur_addr;
  logic [2:0]    beats_left;
  logic [31:0]   shreg;

  logic [15:0]   iq_mem [QDEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] iq_cnt;

  logic rd_pend, wr_pend, wr_accept;
  logic start_wr, start_rd, start_pf, start;
  logic beat_done, last_beat, iq_push, iq_take;
  logic [AW-1:0] st_addr;
  logic [1:0]    st_size;
  logic          st_narrow;
  logic [2:0]    st_beats;
  logic [31:0]   st_shreg, acc_next, wr_shift;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_pend   = op_req && !op_we && !op_ack;
  assign wr_pend   = op_req && op_we && !op_ack;
  assign wr_accept = wr_pend && !wb_full;

  assign start_wr = !busy && wb_full;
  assign start_rd = !busy && !wb_full && rd_pend;
  assign start_pf = !busy && !wb_full && !rd_pend && !wr_pend && !cof_hint && !flush
                    && (iq_cnt < CW'(QDEPTH));
  assign start    = start_wr || start_rd || start_pf;

  assign st_addr   = start_wr ? wb_addr : (start_rd ? op_addr : pf_addr);
  assign st_size   = start_wr ? wb_size : (start_rd ? op_size : SZ_WORD);
  assign st_narrow = (st_size == SZ_BYTE) || narrow_port;

  always_comb begin
    case (st_size)
      SZ_BYTE: st_beats = 3'd1;
      SZ_WORD: st_beats = narrow_port ? 3'd2 : 3'd1;
      default: st_beats = narrow_port ? 3'd4 : 3'd2;
    endcase
    if (!start_wr)               st_shreg = 32'h0;
    else if (wb_size == SZ_BYTE) st_shreg = {wb_data[7:0], 24'h0};
    else if (wb_size == SZ_WORD) st_shreg = {wb_data[15:0], 16'h0};
    else                         st_shreg = wb_data;
  end

  assign beat_done = busy && bus_ack;
  assign last_beat = beat_done && (beats_left == 3'd1);
  assign acc_next  = narrow ? {shreg[23:0], bus_rdata[7:0]} : {shreg[15:0], bus_rdata};
  assign wr_shift  = narrow ? {shreg[23:0], 8'h00} : {shreg[15:0], 16'h0000};

  assign iq_push = last_beat && (kind == K_PF) && !drop && !flush;
  assign iq_take = iq_pop && iq_valid && !flush;

  assign bus_req   = busy;
  assign bus_we    = busy && (kind == K_WR);
  assign bus_byte  = narrow;
  assign bus_addr  = cur_addr;
  assign bus_wdata = (kind != K_WR) ? 16'h0000 :
                     (narrow ? {8'h00, shreg[31:24]} : shreg[31:16]);
  assign iq_valid  = (iq_cnt != '0);
  assign iq_word   = iq_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      kind       <= K_PF;
      drop       <= 1'b0;
      narrow     <= 1'b0;
      cur_addr   <= '0;
      beats_left <= '0;
      shreg      <= '0;
      wb_full    <= 1'b0;
      wb_addr    <= '0;
      wb_size    <= SZ_BYTE;
      wb_data    <= '0;
      op_ack     <= 1'b0;
      op_rdata   <= '0;
      pf_gnt     <= 1'b0;
    end else begin
      op_ack <= 1'b0;
      pf_gnt <= start_pf;
      if (wr_accept) begin
        wb_full <= 1'b1;
        wb_addr <= op_addr;
        wb_size <= op_size;
        wb_data <= op_wdata;
        op_ack  <= 1'b1;
      end
      if (start) begin
        busy       <= 1'b1;
        drop       <= 1'b0;
        kind       <= start_wr ? K_WR : (start_rd ? K_RD : K_PF);
        narrow     <= st_narrow;
        cur_addr   <= st_addr;
        beats_left <= st_beats;
        shreg      <= st_shreg;
      end else begin
        if (flush && busy && kind == K_PF) drop <= 1'b1;
        if (beat_done) begin
          cur_addr   <= cur_addr + (narrow ? AW'(1) : AW'(2));
          beats_left <= beats_left - 3'd1;
          shreg      <= (kind == K_WR) ? wr_shift : acc_next;
          if (last_beat) begin
            busy <= 1'b0;
            if (kind == K_RD) begin
              op_ack   <= 1'b1;
              op_rdata <= acc_next;
            end
            if (kind == K_WR) wb_full <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (iq_push) iq_mem[wr_ptr] <= acc_next[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      iq_cnt <= '0;
    end else begin
      if (iq_push) wr_ptr <= nxt(wr_ptr);
      if (iq_take) rd_ptr <= nxt(rd_ptr);
      if (iq_push && !iq_take)      iq_cnt <= iq_cnt + 1'b1;
      else if (!iq_push && iq_take) iq_cnt <= iq_cnt - 1'b1;
    end
  end

  AST_OP_BEFORE_PF: assert property (@(posedge clk) disable iff (!rst_n)
    pf_gnt |-> $past(!op_req || op_ack)); // R1
  AST_PF_NO_COF: assert property (@(posedge clk) disable iff (!rst_n)
    pf_gnt |-> $past(!cof_hint && !flush)); // R5
  AST_PIPE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(iq_cnt) + int'(busy && kind == K_PF)) <= QDEPTH); // R5
  AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full && $past(wb_full) |-> !op_ack); // R7
  AST_RAW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind == K_RD |-> !wb_full); // R8
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R11
endmodule

// File: tb/bus_cycle_sched_test.sv
module bus_cycle_sched_test;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          op_req = 1'b0, op_we = 1'b0;
  logic [1:0]    op_size = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [31:0]   op_wdata = '0;
  logic          op_ack;
  logic [31:0]   op_rdata;
  logic [AW-1:0] pf_addr = '0;
  logic          cof_hint = 1'b1, flush = 1'b0, pf_gnt, iq_valid, iq_pop = 1'b0;
  logic [15:0]   iq_word;
  logic          narrow_port = 1'b0;
  logic          bus_req, bus_we, bus_byte;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic          bus_ack = 1'b0;
  logic [15:0]   bus_rdata = '0;

  bus_cycle_sched #(.AW(AW), .QDEPTH(3)) uut (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_we(op_we), .op_size(op_size),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_ack(op_ack), .op_rdata(op_rdata),
    .pf_addr(pf_addr), .cof_hint(cof_hint), .flush(flush), .pf_gnt(pf_gnt),
    .iq_valid(iq_valid), .iq_word(iq_word), .iq_pop(iq_pop), .narrow_port(narrow_port),
    .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, log_n = 0;
  logic [AW-1:0] log_addr [128];
  logic [15:0]   log_data [128];
  logic          log_we   [128];
  logic          log_byte [128];
  logic          pf_load = 1'b0;
  logic [AW-1:0] pf_base = '0;

  // fields: size[21:20] narrow[19] addr[18:3] beats[2:0]
  localparam logic [21:0] VEC [0:5] = '{
    {2'd0, 1'b0, 16'h0101, 3'd1},
    {2'd1, 1'b0, 16'h0200, 3'd1},
    {2'd2, 1'b0, 16'h0300, 3'd2},
    {2'd1, 1'b1, 16'h0410, 3'd2},
    {2'd2, 1'b1, 16'h0520, 3'd4},
    {2'd0, 1'b1, 16'h0603, 3'd1}
  };

  function automatic logic [7:0] bv(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] expv(input logic [1:0] sz, input logic [AW-1:0] a);
    int n = (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < n; i++) v = (v << 8) | 32'(bv(a + AW'(i)));
    return v;
  endfunction

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        bus_rdata = bus_byte ? {8'h00, bv(bus_addr)} : {bv(bus_addr), bv(bus_addr + 1)};
        if (log_n < 128) begin
          log_addr[log_n] = bus_addr;
          log_data[log_n] = bus_we ? bus_wdata : bus_rdata;
          log_we[log_n]   = bus_we;
          log_byte[log_n] = bus_byte;
        end
        log_n++;
        bus_ack = 1'b1;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    if (pf_load) pf_addr <= pf_base;
    else if (pf_gnt) pf_addr <= pf_addr + AW'(2);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [AW-1:0] a, output logic [31:0] d);
    bit got = 0;
    @(negedge clk);
    op_req = 1'b1; op_we = 1'b0; op_size = sz; op_addr = a;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (op_ack) got = 1;
    end
    d = op_rdata;
    op_req = 1'b0;
    if (!got) chk(0, "R11", "read ack timeout", 0, 1);
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, output int n);
    bit got = 0;
    @(negedge clk);
    op_req = 1'b1; op_we = 1'b1; op_size = sz; op_addr = a; op_wdata = wd;
    n = 0;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      n++;
      if (op_ack) got = 1;
    end
    op_req = 1'b0; op_we = 1'b0;
    if (!got) chk(0, "R7", "write ack timeout", 0, 1);
  endtask

  task automatic pf_set(input logic [AW-1:0] a);
    @(negedge clk);
    pf_base = a; pf_load = 1'b1;
    @(negedge clk);
    pf_load = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, n2, base, vb, step;
    logic [1:0] vsz;
    logic vp8;
    logic [AW-1:0] va;
    string tag;

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(!bus_req && !op_ack && !iq_valid && !pf_gnt, "R11", "reset state",
        {bus_req, op_ack, iq_valid, pf_gnt}, 0);

    // operand reads, prefetch held off by cof_hint
    for (int v = 0; v < 6; v++) begin
      vsz = VEC[v][21:20];
      vp8 = VEC[v][19];
      va  = {8'h00, VEC[v][18:3]};
      vb  = int'(VEC[v][2:0]);
      narrow_port = vp8;
      lat = v % 3;
      base = log_n;
      do_read(vsz, va, d);
      chk(d == expv(vsz, va), "R11", "read data", d, expv(vsz, va));
      tag = (vp8 && vsz != 2'd0) ? "R4" : ((vsz == 2'd2) ? "R3" : "R2");
      chk(log_n - base == vb, tag, "beat count", log_n - base, vb);
      step = (vsz == 2'd0 || vp8) ? 1 : 2;
      for (int k = 0; k < vb; k++)
        chk(log_addr[base + k] == va + AW'(k * step) && log_byte[base + k] == (step == 1)
            && !log_we[base + k], tag, "beat addr/size",
            {log_byte[base + k], 7'h0, log_addr[base + k]}, {(step == 1), 7'h0, va + AW'(k * step)});
    end

    // write buffer, stall and ordering
    narrow_port = 1'b0;
    lat = 3;
    base = log_n;
    do_write(2'd2, 24'h001000, 32'h11223344, n);
    chk(n == 1 && log_n == base, "R6", "write ack before bus", n, 1);
    do_write(2'd1, 24'h002000, 32'h0000BEEF, n2);
    chk(log_n - base >= 2, "R7", "stalled until first write done", log_n - base, 2);
    chk(n2 > 3, "R7", "second write ack delayed", n2, 4);
    do_read(2'd1, 24'h003000, d);
    chk(log_we[base] && log_addr[base] == 24'h001000 && log_data[base] == 16'h1122,
        "R3", "long write high word first", log_data[base], 16'h1122);
    chk(log_we[base + 1] && log_addr[base + 1] == 24'h001002 && log_data[base + 1] == 16'h3344,
        "R3", "long write low word second", log_data[base + 1], 16'h3344);
    chk(log_we[base + 2] && log_addr[base + 2] == 24'h002000 && log_data[base + 2] == 16'hBEEF,
        "R8", "buffered write before read", log_addr[base + 2], 24'h002000);
    chk(!log_we[base + 3] && log_addr[base + 3] == 24'h003000, "R8", "read after write",
        log_addr[base + 3], 24'h003000);

    base = log_n;
    do_write(2'd0, 24'h004001, 32'h000000C3, n);
    cyc(20);
    chk(log_byte[base] && log_addr[base] == 24'h004001 && log_data[base] == 16'h00C3,
        "R2", "byte write lane", log_data[base], 16'h00C3);

    narrow_port = 1'b1;
    base = log_n;
    do_write(2'd1, 24'h005000, 32'h0000A1B2, n);
    cyc(20);
    chk(log_n - base == 2 && log_byte[base] && log_addr[base] == 24'h005000
        && log_data[base] == 16'h00A1, "R4", "narrow word high byte first", log_data[base], 16'h00A1);
    chk(log_byte[base + 1] && log_addr[base + 1] == 24'h005001 && log_data[base + 1] == 16'h00B2,
        "R4", "narrow word low byte second", log_data[base + 1], 16'h00B2);
    narrow_port = 1'b0;

    // back-to-back prefetch until full
    lat = 0;
    pf_set(24'h008000);
    base = log_n;
    cof_hint = 1'b0;
    cyc(14);
    chk(log_n - base == 3, "R10", "prefetches until full", log_n - base, 3);
    cof_hint = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(iq_valid && iq_word == {bv(24'h008000 + AW'(2 * k)), bv(24'h008001 + AW'(2 * k))},
          "R10", "word order", iq_word, {bv(24'h008000 + AW'(2 * k)), bv(24'h008001 + AW'(2 * k))});
      iq_pop = 1'b1;
      cyc(1);
      iq_pop = 1'b0;
    end
    cyc(10);
    chk(log_n - base == 3 && !iq_valid, "R5", "no prefetch under cof_hint", log_n - base, 3);

    // operand read beats a waiting prefetch
    lat = 6;
    pf_set(24'h009000);
    base = log_n;
    cof_hint = 1'b0;
    cyc(3);
    do_read(2'd1, 24'h006000, d);
    cof_hint = 1'b1;
    chk(log_addr[base] == 24'h009000 && log_addr[base + 1] == 24'h006000 && !log_we[base + 1],
        "R1", "operand before prefetch", log_addr[base + 1], 24'h006000);
    chk(d == expv(2'd1, 24'h006000), "R11", "read data under prefetch", d, expv(2'd1, 24'h006000));
    cyc(20);
    pulse_flush();

    // flush
    lat = 0;
    pf_set(24'h00A000);
    cof_hint = 1'b0;
    cyc(14);
    @(negedge clk);
    flush = 1'b1; cof_hint = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(!iq_valid, "R9", "flush empties pipeline", iq_valid, 0);
    lat = 8;
    base = log_n;
    cof_hint = 1'b0;
    cyc(3);
    chk(bus_req && !bus_we, "R5", "prefetch in flight", bus_req, 1);
    @(negedge clk);
    flush = 1'b1; cof_hint = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    cyc(20);
    chk(log_n - base == 1, "R9", "in-flight fetch completes", log_n - base, 1);
    chk(!iq_valid, "R9", "in-flight word discarded", iq_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule